// File: doc/BRIEF.md
# Receive Gain-Change Settling Sequencer

After every receive gain step, the analog path and the converters need time to settle before anything downstream may trust the signal again. This block watches for the gain-change strobe. It then blanks the peak overload detectors, both the limiter class and the ADC class, through one shared enable. It also holds the power measurement block in reset. Each of the two is released by its own hold-off timer, and both timers count in cycles of the RF-rate clock that drives the block.

The overload hold-off uses the programmed overload wait value as it stands. It applies in every gain control mode, manual mode included. The power-measurement hold-off lasts twice the programmed settling value and applies only while an automatic gain control mode is selected. In manual mode the power measurement still sees a one-cycle reset pulse on each gain change. The block samples all programming inputs at the strobe. A new strobe that arrives while a hold-off is still running restarts both timers from the newly sampled values.

Top module: `gain_settle_seq`

## Requirements
- R1: Out of reset, and whenever no hold-off is running, the detector enable is 1, the power-measurement reset is 0 and busy is 0.
- R2: The clock edge that samples the gain-change strobe high drives the detector enable to 0 and the power-measurement reset to 1.
- R3: For an overload wait value N > 0, the detector enable stays 0 for exactly N cycles after the strobe edge and returns to 1 at the N-th edge after it.
- R4: In AGC mode (mode flag = 1), for a settling value S > 0, the power-measurement reset stays 1 for exactly 2*S cycles after the strobe edge. A settling value of 10 gives the usual 20-cycle hold.
- R5: In manual mode (mode flag = 0), the power-measurement reset is 1 for exactly one cycle after a strobe, whatever the settling value. The overload hold-off still follows R3.
- R6: A programmed value of 0 gives a hold-off of exactly one cycle on the path it controls.
- R7: A strobe that arrives while either hold-off is running restarts both, counting from the strobe edge with the values sampled at that edge.
- R8: The wait value, the settling value and the mode flag are sampled only on the strobe edge. Later changes have no effect on a hold-off already running.
- R9: Busy is 1 exactly when the detector enable is 0 or the power-measurement reset is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gain_chg_i | input | 1 | Gain-change strobe, one cycle per change |
| ovl_wait_i | input | W | Overload detector hold-off, in cycles |
| settle_dly_i | input | W | Settling value; the power-measurement hold is twice this |
| agc_mode_i | input | 1 | 1 = automatic gain control mode, 0 = manual |
| det_en_o | output | 1 | Enable for both overload detector classes |
| pwr_meas_rst_o | output | 1 | Reset for the power measurement block |
| busy_o | output | 1 | High while either hold-off is counting |

## Verification
The bench drives a single strobe with unequal wait and settling values in AGC mode, so that the two release points land on different cycles and the doubling can be seen apart from the plain count. It repeats the strobe in manual mode to separate the one-cycle power pulse from the full settling hold. Zero values and all-ones values probe the two ends of the count range. A second strobe fired mid-hold, and input changes made during a hold, tell restart-from-full apart from continuing or re-sampling, in the cycle where each output changes.

// File: rtl/gss_pkg.sv
package gss_pkg;

  // Hold length of the overload path: the wait value, never below one cycle.
  function automatic logic [31:0] ovl_hold_len(input logic [31:0] wait_val);
    return (wait_val == 32'd0) ? 32'd1 : wait_val;
  endfunction

  // Hold length of the power path: twice the settling value in AGC mode,
  // a single cycle in manual mode or for a zero value.
  function automatic logic [31:0] pwr_hold_len(input logic [31:0] settle_val,
                                               input logic        agc);
    logic [31:0] dbl;
    dbl = settle_val << 1;
    if (!agc || dbl == 32'd0) return 32'd1;
    return dbl;
  endfunction

endpackage

// File: rtl/gss_hold_calc.sv
module gss_hold_calc #(
  parameter int W   = 8,
  parameter int OCW = W,
  parameter int PCW = W + 1
) (
  input  logic [W-1:0]   ovl_wait_i,
  input  logic [W-1:0]   settle_dly_i,
  input  logic           agc_mode_i,
  output logic [OCW-1:0] ovl_len_o,
  output logic [PCW-1:0] pwr_len_o
);
  import gss_pkg::*;

  always_comb begin
    ovl_len_o = OCW'(ovl_hold_len(32'(ovl_wait_i)));
    pwr_len_o = PCW'(pwr_hold_len(32'(settle_dly_i), agc_mode_i));
  end

endmodule

// File: rtl/gss_holdoff_timer.sv
module gss_holdoff_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic [CW-1:0] cnt_o,
  output logic          running_o,
  output logic          expire_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - ONE;
  end

  assign cnt_o     = cnt_q;
  assign running_o = (cnt_q != '0);
  assign expire_o  = (cnt_q == ONE) && !load_i;

endmodule

// File: rtl/gain_settle_seq.sv
module gain_settle_seq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gain_chg_i,
  input  logic [W-1:0] ovl_wait_i,
  input  logic [W-1:0] settle_dly_i,
  input  logic         agc_mode_i,
  output logic         det_en_o,
  output logic         pwr_meas_rst_o,
  output logic         busy_o
);
  localparam int OCW = W;
  localparam int PCW = W + 1;

  // Named internal events, visible to the bound checker.
  logic           gain_evt;
  logic [OCW-1:0] ovl_len;
  logic [PCW-1:0] pwr_len;
  logic [OCW-1:0] ovl_cnt;
  logic [PCW-1:0] pwr_cnt;
  logic           ovl_running;
  logic           pwr_running;
  logic           ovl_expire;
  logic           pwr_expire;

  assign gain_evt = gain_chg_i;

  gss_hold_calc #(.W(W), .OCW(OCW), .PCW(PCW)) u_calc (
    .ovl_wait_i  (ovl_wait_i),
    .settle_dly_i(settle_dly_i),
    .agc_mode_i  (agc_mode_i),
    .ovl_len_o   (ovl_len),
    .pwr_len_o   (pwr_len)
  );

  // Overload detector hold-off: used in every gain control mode.
  gss_holdoff_timer #(.CW(OCW)) u_ovl_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (gain_evt),
    .len_i    (ovl_len),
    .cnt_o    (ovl_cnt),
    .running_o(ovl_running),
    .expire_o (ovl_expire)
  );

  // Power measurement hold-off: doubled settling value, one extra bit.
  gss_holdoff_timer #(.CW(PCW)) u_pwr_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (gain_evt),
    .len_i    (pwr_len),
    .cnt_o    (pwr_cnt),
    .running_o(pwr_running),
    .expire_o (pwr_expire)
  );

  assign det_en_o       = !ovl_running;
  assign pwr_meas_rst_o = pwr_running;
  assign busy_o         = ovl_running | pwr_running;

endmodule

// File: rtl/gss_settle_chk.sv
module gss_settle_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         gain_chg_i,
  input logic [W-1:0] ovl_wait_i,
  input logic [W-1:0] settle_dly_i,
  input logic         agc_mode_i,
  input logic         det_en_o,
  input logic         pwr_meas_rst_o,
  input logic         busy_o,
  input logic         ovl_expire,
  input logic         pwr_expire
);
  localparam int SW = W + 2;
  localparam logic [SW-1:0] SMAX = '1;

  logic [SW-1:0] since_q;
  logic [SW-1:0] exp_ovl_q;
  logic [SW-1:0] exp_pwr_q;
  logic          agc_q;

  // Cycles since the last strobe edge, with the lengths that edge expects.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q   <= SMAX;
      exp_ovl_q <= '0;
      exp_pwr_q <= '0;
      agc_q     <= 1'b0;
    end else if (gain_chg_i) begin
      since_q   <= '0;
      exp_ovl_q <= (ovl_wait_i == '0) ? SW'(1) : SW'(ovl_wait_i);
      exp_pwr_q <= (agc_mode_i && settle_dly_i != '0) ? SW'(settle_dly_i) + SW'(settle_dly_i) : SW'(1);
      agc_q     <= agc_mode_i;
    end else if (since_q != SMAX) begin
      since_q   <= since_q + SW'(1);
    end
  end

  p_blank_on_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gain_chg_i |=> (!det_en_o && pwr_meas_rst_o));

  p_ovl_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_en_o) |-> (since_q == exp_ovl_q));

  p_pwr_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_meas_rst_o) |-> (since_q == exp_pwr_q));

  p_manual_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_meas_rst_o && !agc_q && !gain_chg_i) |=> !pwr_meas_rst_o);

  p_expire_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_expire && !gain_chg_i) |=> det_en_o);

  p_pwr_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_expire && !gain_chg_i) |=> !pwr_meas_rst_o);

  p_busy_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o == (!det_en_o || pwr_meas_rst_o));

endmodule

bind gain_settle_seq gss_settle_chk #(.W(W)) u_settle_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .gain_chg_i    (gain_chg_i),
  .ovl_wait_i    (ovl_wait_i),
  .settle_dly_i  (settle_dly_i),
  .agc_mode_i    (agc_mode_i),
  .det_en_o      (det_en_o),
  .pwr_meas_rst_o(pwr_meas_rst_o),
  .busy_o        (busy_o),
  .ovl_expire    (ovl_expire),
  .pwr_expire    (pwr_expire)
);

// File: tb/tb_gain_settle_seq.sv
module tb_gain_settle_seq;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         gain_chg = 1'b0;
  logic [W-1:0] ovl_wait = '0;
  logic [W-1:0] settle_dly = '0;
  logic         agc_mode = 1'b0;
  logic         det_en, pwr_rst, busy;

  always #5 clk = ~clk;

  gain_settle_seq #(.W(W)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .gain_chg_i    (gain_chg),
    .ovl_wait_i    (ovl_wait),
    .settle_dly_i  (settle_dly),
    .agc_mode_i    (agc_mode),
    .det_en_o      (det_en),
    .pwr_meas_rst_o(pwr_rst),
    .busy_o        (busy)
  );

  typedef struct packed { logic det; logic pwr; logic bsy; } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    vectors = 0;
  int    miscompares = 0;
  int    edge_no = 0;
  int    ovl_rel = 0;
  int    pwr_rel = 0;
  bit    done = 0;

  // Driver: one cycle of stimulus, then the expected outputs after that edge.
  task automatic step(input logic chg, input int ow, input int sd,
                      input logic agc, input string tag);
    exp_t e;
    @(negedge clk);
    gain_chg   = chg;
    ovl_wait   = W'(ow);
    settle_dly = W'(sd);
    agc_mode   = agc;
    @(posedge clk);
    edge_no++;
    if (chg) begin
      ovl_rel = edge_no + ((ow == 0) ? 1 : ow);
      pwr_rel = edge_no + ((agc && sd != 0) ? 2 * sd : 1);
    end
    e.det = (edge_no >= ovl_rel);
    e.pwr = (edge_no < pwr_rel);
    e.bsy = !e.det || e.pwr;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input int ow, input int sd,
                      input logic agc, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, ow, sd, agc, tag);
  endtask

  // Monitor: compare away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (det_en !== e.det || pwr_rst !== e.pwr || busy !== e.bsy) begin
          miscompares++;
          $display("FAIL %s edge %0d: det_en=%b exp %b, pwr_rst=%b exp %b, busy=%b exp %b",
                   t, edge_no, det_en, e.det, pwr_rst, e.pwr, busy, e.bsy);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    if (det_en !== 1'b1 || pwr_rst !== 1'b0 || busy !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset: det_en=%b pwr_rst=%b busy=%b exp 1 0 0", det_en, pwr_rst, busy);
    end
    rst_n = 1'b1;

    idle(3, 0, 0, 1'b1, "R1 idle");
    // R2 R3 R4: unequal release points in AGC mode.
    step(1'b1, 5, 3, 1'b1, "R2 R3 R4 strobe");
    idle(10, 5, 3, 1'b1, "R3 R4 hold");
    // R4: settling value 10 gives a 20-cycle hold.
    step(1'b1, 7, 10, 1'b1, "R4 default strobe");
    idle(24, 7, 10, 1'b1, "R4 default hold");
    // R5: manual mode, one-cycle power pulse, overload wait still applies.
    step(1'b1, 4, 9, 1'b0, "R5 manual strobe");
    idle(7, 4, 9, 1'b0, "R5 manual hold");
    // R6: zero values give one-cycle holds.
    step(1'b1, 0, 0, 1'b1, "R6 zero strobe");
    idle(3, 0, 0, 1'b1, "R6 zero hold");
    step(1'b1, 0, 6, 1'b1, "R6 zero ovl strobe");
    idle(14, 0, 6, 1'b1, "R6 zero ovl hold");
    // R7: retrigger mid-hold, restart from full.
    step(1'b1, 6, 4, 1'b1, "R7 first strobe");
    idle(3, 6, 4, 1'b1, "R7 mid hold");
    step(1'b1, 6, 4, 1'b1, "R7 restart strobe");
    idle(10, 6, 4, 1'b1, "R7 restart hold");
    step(1'b1, 9, 5, 1'b1, "R7 first strobe b");
    idle(2, 9, 5, 1'b1, "R7 mid hold b");
    step(1'b1, 2, 1, 1'b1, "R7 shorter restart");
    idle(5, 2, 1, 1'b1, "R7 shorter hold");
    // R8: inputs change during the hold.
    step(1'b1, 3, 2, 1'b1, "R8 strobe");
    idle(8, 15, 15, 1'b0, "R8 changed inputs");
    step(1'b1, 2, 2, 1'b0, "R8 manual strobe");
    idle(6, 2, 2, 1'b1, "R8 agc set mid hold");
    // R9 and the top of the range.
    step(1'b1, 255, 255, 1'b1, "R9 max strobe");
    idle(515, 255, 255, 1'b1, "R9 max hold");

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule